// File: doc/BRIEF.md
# Paired-Destination Register File

This block holds eight 16-bit general-purpose registers for a small 16-bit processor core. Two combinational read ports return the contents of the first and second source registers. The first source address also names the destination. A primary write port stores an ordinary result there. A secondary write port stores a second result word into the register that follows the destination.

The secondary port serves operations that produce two words at once. A product splits into a low half for the destination and a high half for the next register. A division gives a quotient for the destination and a remainder for the next register. Both words commit on one rising clock edge, so a double-width result does not need a second cycle. Register numbering wraps, so register 7 pairs with register 0.

Top module: `pair_write_regfile`

## Requirements
- R1: A synchronous reset, `rst` active high, clears all eight registers to zero on the rising edge where it is sampled high.
- R2: `rsData` always equals the register selected by `rsAddr`, combinationally, with no clock between address and data.
- R3: `rtData` always equals the register selected by `rtAddr`, combinationally.
- R4: With `priWrEn` high at a rising edge, the register numbered `rsAddr` takes `priWrData`.
- R5: With `secWrEn` high at a rising edge, the register numbered `rsAddr + 1` takes `secWrData`.
- R6: The secondary target wraps modulo 8, so `rsAddr` = 7 makes register 0 the target of `secWrData`.
- R7: With both enables high at one edge, both target registers update on that same edge.
- R8: Before the committing edge, both read ports still return the old contents of a register that is about to be written.
- R9: At an edge with both enables low, no register changes, whatever the data and address inputs hold. At an edge with writes enabled, registers that are not targets keep their values.
- R10: Reset has priority over both write enables. A write requested at an edge where `rst` is high is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| rsAddr | input | 3 | First source register number; also the destination |
| rtAddr | input | 3 | Second source register number |
| rsData | output | 16 | Contents of register `rsAddr` |
| rtData | output | 16 | Contents of register `rtAddr` |
| priWrEn | input | 1 | Primary write enable (target `rsAddr`) |
| priWrData | input | 16 | Primary write data |
| secWrEn | input | 1 | Secondary write enable (target `rsAddr + 1` mod 8) |
| secWrData | input | 16 | Secondary write data |

## Verification
A vector table drives single primary writes, single secondary writes, paired writes at a middle address and paired writes at register 7. After each edge, every register is read through both ports, so a write that lands on the wrong register, or fails to wrap, shows up as a disturbed neighbour. A vector with both enables low and non-zero data separates a true idle edge from a write that leaks past its enable. Directed steps then probe the reads just before a committing edge (R8). They also apply reset together with active writes, which shows whether reset outranks the enables.

// File: rtl/prf_pkg.sv
package prf_pkg;
  localparam int PRF_NUM_REGS = 8;
  localparam int PRF_DATA_W   = 16;
  localparam int PRF_ADDR_W   = $clog2(PRF_NUM_REGS);

  typedef struct packed {
    logic                    clearAll;
    logic [PRF_NUM_REGS-1:0] priSel;
    logic [PRF_NUM_REGS-1:0] secSel;
  } prfStrobes_t;
endpackage

// File: rtl/prf_ctrl.sv
module prf_ctrl
  import prf_pkg::*;
#(
  parameter int NUM_REGS = PRF_NUM_REGS,
  parameter int ADDR_W   = PRF_ADDR_W
) (
  input  logic              rst,
  input  logic [ADDR_W-1:0] rsAddr,
  input  logic              priWrEn,
  input  logic              secWrEn,
  output prfStrobes_t       strobes
);
  localparam logic [ADDR_W-1:0] LAST_REG = ADDR_W'(NUM_REGS - 1);

  logic [ADDR_W-1:0] secAddr;

  // Register after the destination, wrapping past the top entry.
  always_comb begin
    if (rsAddr == LAST_REG) secAddr = '0;
    else                    secAddr = rsAddr + ADDR_W'(1);
  end

  assign strobes.clearAll = rst;

  for (genvar g = 0; g < NUM_REGS; g++) begin : gSel
    assign strobes.priSel[g] = priWrEn && (rsAddr  == ADDR_W'(g));
    assign strobes.secSel[g] = secWrEn && (secAddr == ADDR_W'(g));
  end
endmodule

// File: rtl/prf_datapath.sv
module prf_datapath
  import prf_pkg::*;
#(
  parameter int NUM_REGS = PRF_NUM_REGS,
  parameter int DATA_W   = PRF_DATA_W,
  parameter int ADDR_W   = PRF_ADDR_W
) (
  input  logic              clk,
  input  prfStrobes_t       strobes,
  input  logic [DATA_W-1:0] priWrData,
  input  logic [DATA_W-1:0] secWrData,
  input  logic [ADDR_W-1:0] rsAddr,
  input  logic [ADDR_W-1:0] rtAddr,
  output logic [DATA_W-1:0] rsData,
  output logic [DATA_W-1:0] rtData
);
  logic [DATA_W-1:0] regQ [NUM_REGS];

  always_ff @(posedge clk) begin
    for (int i = 0; i < NUM_REGS; i++) begin
      if (strobes.clearAll)      regQ[i] <= '0;
      else if (strobes.priSel[i]) regQ[i] <= priWrData;
      else if (strobes.secSel[i]) regQ[i] <= secWrData;
    end
  end

  assign rsData = regQ[rsAddr];
  assign rtData = regQ[rtAddr];
endmodule

// File: rtl/pair_write_regfile.sv
module pair_write_regfile
  import prf_pkg::*;
#(
  parameter int NUM_REGS = PRF_NUM_REGS,
  parameter int DATA_W   = PRF_DATA_W,
  parameter int ADDR_W   = PRF_ADDR_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] rsAddr,
  input  logic [ADDR_W-1:0] rtAddr,
  output logic [DATA_W-1:0] rsData,
  output logic [DATA_W-1:0] rtData,
  input  logic              priWrEn,
  input  logic [DATA_W-1:0] priWrData,
  input  logic              secWrEn,
  input  logic [DATA_W-1:0] secWrData
);
  prfStrobes_t strobes;

  prf_ctrl #(.NUM_REGS(NUM_REGS), .ADDR_W(ADDR_W)) i_ctrl (
    .rst     (rst),
    .rsAddr  (rsAddr),
    .priWrEn (priWrEn),
    .secWrEn (secWrEn),
    .strobes (strobes)
  );

  prf_datapath #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) i_dp (
    .clk       (clk),
    .strobes   (strobes),
    .priWrData (priWrData),
    .secWrData (secWrData),
    .rsAddr    (rsAddr),
    .rtAddr    (rtAddr),
    .rsData    (rsData),
    .rtData    (rtData)
  );
endmodule

// File: rtl/prf_checker.sv
module prf_checker #(
  parameter int NUM_REGS = 8,
  parameter int DATA_W   = 16,
  parameter int ADDR_W   = 3
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] rsAddr,
  input logic [ADDR_W-1:0] rtAddr,
  input logic [DATA_W-1:0] rsData,
  input logic [DATA_W-1:0] rtData,
  input logic              priWrEn,
  input logic [DATA_W-1:0] priWrData,
  input logic              secWrEn,
  input logic [DATA_W-1:0] secWrData
);
  function automatic logic [ADDR_W-1:0] nextReg(input logic [ADDR_W-1:0] a);
    return (int'(a) == NUM_REGS - 1) ? '0 : a + ADDR_W'(1);
  endfunction

  p_reset_clear_r1: assert property (@(posedge clk)
    rst |=> (rsData == '0 && rtData == '0));

  p_same_addr_r2: assert property (@(posedge clk) disable iff (rst)
    (rsAddr == rtAddr) |-> (rsData == rtData));

  p_pri_commit_r4: assert property (@(posedge clk) disable iff (rst)
    priWrEn |=> ((rsAddr == $past(rsAddr)) -> (rsData == $past(priWrData))));

  p_sec_commit_r5: assert property (@(posedge clk) disable iff (rst)
    secWrEn |=> ((rtAddr == nextReg($past(rsAddr))) -> (rtData == $past(secWrData))));

  p_idle_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (!priWrEn && !secWrEn) |=> ((rsAddr == $past(rsAddr)) -> $stable(rsData)));
endmodule

bind pair_write_regfile prf_checker #(
  .NUM_REGS(NUM_REGS), .DATA_W(DATA_W), .ADDR_W(ADDR_W)
) i_prf_checker (
  .clk(clk), .rst(rst), .rsAddr(rsAddr), .rtAddr(rtAddr),
  .rsData(rsData), .rtData(rtData), .priWrEn(priWrEn),
  .priWrData(priWrData), .secWrEn(secWrEn), .secWrData(secWrData)
);

// File: tb/test_pair_write_regfile.sv
module test_pair_write_regfile;
  timeunit 1ns;
  timeprecision 100ps;

  logic        clk = 1'b0;
  logic        rst;
  logic [2:0]  rsAddr, rtAddr;
  logic [15:0] rsData, rtData;
  logic        priWrEn, secWrEn;
  logic [15:0] priWrData, secWrData;

  int testsRun = 0;
  int testsFailed = 0;
  bit finished = 1'b0;
  logic [15:0] model [8];

  always #2.5 clk = ~clk;

  pair_write_regfile i_pair_write_regfile (
    .clk(clk), .rst(rst), .rsAddr(rsAddr), .rtAddr(rtAddr),
    .rsData(rsData), .rtData(rtData), .priWrEn(priWrEn),
    .priWrData(priWrData), .secWrEn(secWrEn), .secWrData(secWrData)
  );

  // {rs, priEn, priData, secEn, secData}
  localparam int NVEC = 8;
  localparam logic [36:0] VEC [NVEC] = '{
    {3'd2, 1'b1, 16'h1234, 1'b0, 16'h5555},  // R4 primary only
    {3'd3, 1'b0, 16'h9999, 1'b1, 16'hBEEF},  // R5 secondary only -> reg 4
    {3'd5, 1'b1, 16'h00FF, 1'b1, 16'hA5A5},  // R7 pair -> regs 5,6
    {3'd7, 1'b1, 16'h7777, 1'b1, 16'h8001},  // R6 wrap -> regs 7,0
    {3'd0, 1'b0, 16'hDEAD, 1'b0, 16'hCAFE},  // R9 idle edge
    {3'd1, 1'b1, 16'hFFFF, 1'b0, 16'h0000},  // R4
    {3'd6, 1'b0, 16'h1111, 1'b1, 16'h0F0F},  // R5 -> reg 7
    {3'd4, 1'b1, 16'h0000, 1'b1, 16'hFFFF}   // R7 pair -> regs 4,5
  };

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    testsRun++;
    if (act !== exp) begin
      testsFailed++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Read every register through both ports (R2, R3).
  task automatic sweep(input string tag);
    for (int a = 0; a < 8; a++) begin
      rsAddr = 3'(a);
      rtAddr = 3'(7 - a);
      #0.2;
      check($sformatf("R2 %s reg %0d", tag, a), rsData, model[a]);
      check($sformatf("R3 %s reg %0d", tag, 7 - a), rtData, model[7 - a]);
    end
  endtask

  task automatic applyWrite(input logic [2:0] rs, input logic pe, input logic [15:0] pd,
                            input logic se, input logic [15:0] sd);
    @(negedge clk);
    rsAddr = rs; priWrEn = pe; priWrData = pd; secWrEn = se; secWrData = sd;
    @(posedge clk);
    #0.5;
    priWrEn = 1'b0; secWrEn = 1'b0;
    if (pe) model[rs] = pd;
    if (se) model[3'(rs + 3'd1)] = sd;
  endtask

  initial begin
    #100000;
    if (!finished) begin
      testsFailed++;
      testsRun++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; rsAddr = '0; rtAddr = '0;
    priWrEn = 1'b0; secWrEn = 1'b0; priWrData = '0; secWrData = '0;
    for (int i = 0; i < 8; i++) model[i] = '0;
    repeat (2) @(posedge clk);
    #0.5 rst = 1'b0;
    sweep("R1 after reset");

    // Table of vectors, each followed by a full readback (R4 R5 R6 R7 R9).
    for (int v = 0; v < NVEC; v++) begin
      applyWrite(VEC[v][36:34], VEC[v][33], VEC[v][32:17], VEC[v][16], VEC[v][15:0]);
      sweep($sformatf("vec %0d", v));
    end

    // R8: old contents visible before the committing edge.
    @(negedge clk);
    rsAddr = 3'd2; rtAddr = 3'd3;
    priWrEn = 1'b1; priWrData = 16'h4242;
    secWrEn = 1'b1; secWrData = 16'h2424;
    #0.5;
    check("R8 rs before edge", rsData, model[2]);
    check("R8 rt before edge", rtData, model[3]);
    @(posedge clk);
    #0.5;
    priWrEn = 1'b0; secWrEn = 1'b0;
    model[2] = 16'h4242; model[3] = 16'h2424;
    rsAddr = 3'd2; rtAddr = 3'd3;
    #0.2;
    check("R8 rs after edge", rsData, 16'h4242);
    check("R8 rt after edge", rtData, 16'h2424);

    // R10 and R1: reset together with active writes clears everything.
    @(negedge clk);
    rst = 1'b1; rsAddr = 3'd6;
    priWrEn = 1'b1; priWrData = 16'h9876;
    secWrEn = 1'b1; secWrData = 16'h6789;
    @(posedge clk);
    #0.5;
    rst = 1'b0; priWrEn = 1'b0; secWrEn = 1'b0;
    for (int i = 0; i < 8; i++) model[i] = '0;
    sweep("R10 R1 reset over writes");

    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end
endmodule